// File: doc/BRIEF.md
# L1 Shadow-Tag Coherence Directory

This block sits next to one bank of a shared cache and keeps a copy of the tags of every attached write-through L1 data cache. Each copy is indexed by L1 set and way. An L1 allocates a line only on a load miss. The load miss reaches this block with the way the L1 chose to replace, and the block writes the line's tag into that core's copy at the same set and way.

Stores never allocate in an L1. Every store looks up all copies in the store's set. It builds a mask with one bit for each core whose copy holds the line, and this includes the storing core. The mask and the line address are pushed as one entry into an invalidate queue, and the matching copies are cleared. One cycle later the store is acknowledged as complete.

All cores share the queue, so every L1 sees its invalidates in the order the directory processed the stores. When the queue is full, stores stall. A load miss to the set of a store presented in the same cycle waits, so the store is handled first.

Top module: `shadow_dir`

## Requirements
- R1: After reset, inv_valid_o is 0, st_ready_o is 1, st_ack_o is 0, and no shadow entry is valid, so no store queues an invalidate until a load miss has been recorded.
- R2: A line address is {tag, set}, with the set in the low SET_W bits. An accepted load miss from core c into way w makes core c's entry at (set, w) valid with that tag.
- R3: An accepted store queues one entry whose mask has bit c set for each core c that has a valid matching entry in any way of the store's set. This includes the storing core.
- R4: A store that matches no entry queues nothing and is still acknowledged.
- R5: An accepted store clears every matching entry. A second store to the same line, with no load miss to that line in between, queues nothing.
- R6: A load miss into a way overwrites the tag held there, and the old line is no longer tracked in that way.
- R7: st_ack_o is 1 in the cycle after each accepted store and 0 otherwise. st_ack_core_o carries that store's core ID.
- R8: Queue entries leave in the order they were pushed. inv_addr_o is the store's line address. The head entry stays stable while inv_ready_i is 0, and a valid entry never has an empty mask.
- R9: When a store is valid in the same cycle and its set equals the load miss's set, ld_ready_o is 0. The load is taken in a later cycle, after the store.
- R10: st_ready_o is 0 exactly when the queue holds INV_DEPTH entries. A stalled store is neither acknowledged nor applied.
- R11: A load miss and a store to different sets in the same cycle are both accepted.
- R12: The match compares the full tag. A store to the same set with a different tag leaves the entry valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ld_valid_i | input | 1 | Load-miss request valid |
| ld_ready_o | output | 1 | Load miss accepted this cycle |
| ld_core_i | input | CORE_W | Core that missed |
| ld_line_i | input | LINE_W | Line address of the miss |
| ld_way_i | input | WAY_W | Replacement way chosen by the L1 |
| st_valid_i | input | 1 | Store request valid |
| st_ready_o | output | 1 | Store accepted this cycle |
| st_core_i | input | CORE_W | Storing core |
| st_line_i | input | LINE_W | Line address of the store |
| inv_valid_o | output | 1 | Invalidate queue head valid |
| inv_ready_i | input | 1 | Head consumed |
| inv_mask_o | output | NUM_CORES | Cores to invalidate |
| inv_addr_o | output | LINE_W | Line to invalidate |
| st_ack_o | output | 1 | Store complete |
| st_ack_core_o | output | CORE_W | Core of the completed store |

## Verification
The case that is hardest to reach is a stall caused by a full queue. It needs several back-to-back stores that each hit a tracked line while nothing drains the queue. A directed sequence first installs five lines in distinct sets and then stores to all five with inv_ready_i held low. Same-set collisions between a load miss and a store are rare under random traffic. For that reason the random phase draws lines from four sets and four tags, and a directed step sets up the collision on purpose.

// File: rtl/shadow_dir_pkg.sv
package shadow_dir_pkg;
  localparam int unsigned DEF_CORES = 8;
  localparam int unsigned DEF_SETS  = 64;
  localparam int unsigned DEF_WAYS  = 4;
  localparam int unsigned DEF_ADDR_W = 32;
  localparam int unsigned DEF_OFF_W  = 4;
  localparam int unsigned DEF_INV_DEPTH = 4;
endpackage

// File: rtl/shadow_dir_tag_array.sv
module shadow_dir_tag_array #(
  parameter int unsigned NUM_SETS = 64,
  parameter int unsigned NUM_WAYS = 4,
  parameter int unsigned TAG_W    = 22,
  localparam int unsigned SET_W   = $clog2(NUM_SETS),
  localparam int unsigned WAY_W   = $clog2(NUM_WAYS)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [SET_W-1:0]    rd_set_i,
  input  logic [TAG_W-1:0]    rd_tag_i,
  input  logic                clr_i,
  output logic [NUM_WAYS-1:0] hit_o,
  input  logic                wr_en_i,
  input  logic [SET_W-1:0]    wr_set_i,
  input  logic [WAY_W-1:0]    wr_way_i,
  input  logic [TAG_W-1:0]    wr_tag_i
);
  logic             vld_q [NUM_SETS][NUM_WAYS];
  logic [TAG_W-1:0] tag_q [NUM_SETS][NUM_WAYS];

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++)
      hit_o[w] = vld_q[rd_set_i][w] && (tag_q[rd_set_i][w] == rd_tag_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < NUM_SETS; s++)
        for (int w = 0; w < NUM_WAYS; w++)
          vld_q[s][w] <= 1'b0;
    end else begin
      if (clr_i)
        for (int w = 0; w < NUM_WAYS; w++)
          if (hit_o[w]) vld_q[rd_set_i][w] <= 1'b0;
      // load and store never share a set in one cycle
      if (wr_en_i) vld_q[wr_set_i][wr_way_i] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) tag_q[wr_set_i][wr_way_i] <= wr_tag_i;
  end
endmodule

// File: rtl/shadow_dir_inv_fifo.sv
module shadow_dir_inv_fifo #(
  parameter int unsigned W     = 36,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         pop_i,
  output logic [W-1:0] data_o
);
  logic [W-1:0]  mem_q [DEPTH];
  logic [PW-1:0] rd_q, wr_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && valid_o;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      cnt_q <= cnt_q + CW'(do_push) - CW'(do_pop);
    end
  end

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R8
  head_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_o && !pop_i) |=> (valid_o && $stable(data_o)));
endmodule

// File: rtl/shadow_dir.sv
module shadow_dir
  import shadow_dir_pkg::*;
#(
  parameter int unsigned NUM_CORES = DEF_CORES,
  parameter int unsigned NUM_SETS  = DEF_SETS,
  parameter int unsigned NUM_WAYS  = DEF_WAYS,
  parameter int unsigned ADDR_W    = DEF_ADDR_W,
  parameter int unsigned OFF_W     = DEF_OFF_W,
  parameter int unsigned INV_DEPTH = DEF_INV_DEPTH,
  localparam int unsigned CORE_W   = $clog2(NUM_CORES),
  localparam int unsigned SET_W    = $clog2(NUM_SETS),
  localparam int unsigned WAY_W    = $clog2(NUM_WAYS),
  localparam int unsigned LINE_W   = ADDR_W - OFF_W,
  localparam int unsigned TAG_W    = LINE_W - SET_W
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 ld_valid_i,
  output logic                 ld_ready_o,
  input  logic [CORE_W-1:0]    ld_core_i,
  input  logic [LINE_W-1:0]    ld_line_i,
  input  logic [WAY_W-1:0]     ld_way_i,
  input  logic                 st_valid_i,
  output logic                 st_ready_o,
  input  logic [CORE_W-1:0]    st_core_i,
  input  logic [LINE_W-1:0]    st_line_i,
  output logic                 inv_valid_o,
  input  logic                 inv_ready_i,
  output logic [NUM_CORES-1:0] inv_mask_o,
  output logic [LINE_W-1:0]    inv_addr_o,
  output logic                 st_ack_o,
  output logic [CORE_W-1:0]    st_ack_core_o
);
  localparam int unsigned ENT_W = NUM_CORES + LINE_W;

  logic [SET_W-1:0]    st_set, ld_set;
  logic [TAG_W-1:0]    st_tag, ld_tag;
  logic                st_acc, ld_acc, q_full, push;
  logic [NUM_WAYS-1:0] hit [NUM_CORES];
  logic [NUM_CORES-1:0] mask;

  assign st_set = st_line_i[SET_W-1:0];
  assign st_tag = st_line_i[LINE_W-1:SET_W];
  assign ld_set = ld_line_i[SET_W-1:0];
  assign ld_tag = ld_line_i[LINE_W-1:SET_W];

  assign st_ready_o = !q_full;
  assign st_acc     = st_valid_i && st_ready_o;
  // store wins a same-set collision
  assign ld_ready_o = !(st_valid_i && (st_set == ld_set));
  assign ld_acc     = ld_valid_i && ld_ready_o;

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    shadow_dir_tag_array #(
      .NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS), .TAG_W(TAG_W)
    ) u_arr (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .rd_set_i (st_set),
      .rd_tag_i (st_tag),
      .clr_i    (st_acc),
      .hit_o    (hit[c]),
      .wr_en_i  (ld_acc && (ld_core_i == CORE_W'(c))),
      .wr_set_i (ld_set),
      .wr_way_i (ld_way_i),
      .wr_tag_i (ld_tag)
    );
    assign mask[c] = |hit[c];
  end

  assign push = st_acc && (mask != '0);

  shadow_dir_inv_fifo #(.W(ENT_W), .DEPTH(INV_DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  ({mask, st_line_i}),
    .full_o  (q_full),
    .valid_o (inv_valid_o),
    .pop_i   (inv_ready_i),
    .data_o  ({inv_mask_o, inv_addr_o})
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_ack_o      <= 1'b0;
      st_ack_core_o <= '0;
    end else begin
      st_ack_o <= st_acc;
      if (st_acc) st_ack_core_o <= st_core_i;
    end
  end

  // R7
  ack_follows_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_acc |=> (st_ack_o && st_ack_core_o == $past(st_core_i)));

  // R8
  mask_nonzero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inv_valid_o |-> ($countones(inv_mask_o) > 0));

  // R5
  cleared_after_store_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_acc && $past(st_acc) && !$past(ld_acc) && (st_line_i == $past(st_line_i)))
      |-> (mask == '0));

  // R9
  collision_order_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ld_acc && st_valid_i) |-> (ld_set != st_set));
endmodule

// File: tb/shadow_dir_tb_top.sv
module shadow_dir_tb_top;
  localparam int NC = 8, NS = 64, NW = 4, LW = 28, SW = 6, TW = 22, DEPTH = 4;

  logic clk = 0, rst_n = 0;
  always #2 clk = ~clk;

  logic          ld_valid, ld_ready, st_valid, st_ready, inv_valid, inv_ready, st_ack;
  logic [2:0]    ld_core, st_core, st_ack_core;
  logic [LW-1:0] ld_line, st_line, inv_addr;
  logic [1:0]    ld_way;
  logic [NC-1:0] inv_mask;

  shadow_dir dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ld_valid_i(ld_valid), .ld_ready_o(ld_ready), .ld_core_i(ld_core),
    .ld_line_i(ld_line), .ld_way_i(ld_way),
    .st_valid_i(st_valid), .st_ready_o(st_ready), .st_core_i(st_core),
    .st_line_i(st_line),
    .inv_valid_o(inv_valid), .inv_ready_i(inv_ready), .inv_mask_o(inv_mask),
    .inv_addr_o(inv_addr), .st_ack_o(st_ack), .st_ack_core_o(st_ack_core)
  );

  int checks = 0, errors = 0;
  bit          m_v [NC][NS][NW];
  logic [TW-1:0] m_t [NC][NS][NW];
  logic [NC-1:0] q_m [$];
  logic [LW-1:0] q_a [$];

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [LW-1:0] mk(input int tag, input int set);
    return {TW'(tag), SW'(set)};
  endfunction

  function automatic logic [NC-1:0] exp_mask(input logic [LW-1:0] ln);
    logic [NC-1:0] m = '0;
    for (int c = 0; c < NC; c++)
      for (int w = 0; w < NW; w++)
        if (m_v[c][ln[SW-1:0]][w] && m_t[c][ln[SW-1:0]][w] == ln[LW-1:SW]) m[c] = 1'b1;
    return m;
  endfunction

  // one clock: drive at negedge, check comb outputs, advance model, check ack
  task automatic cycle(input bit lv, input int lc, input logic [LW-1:0] la, input int lw,
                       input bit sv, input int sc, input logic [LW-1:0] sa, input bit pop);
    bit e_srdy, e_lrdy, s_acc, l_acc;
    logic [NC-1:0] m;
    ld_valid = lv; ld_core = 3'(lc); ld_line = la; ld_way = 2'(lw);
    st_valid = sv; st_core = 3'(sc); st_line = sa; inv_ready = pop;
    #1;
    e_srdy = (q_m.size() < DEPTH);
    e_lrdy = !(sv && sa[SW-1:0] == la[SW-1:0]);
    chk("R10 st_ready", 32'(st_ready), 32'(e_srdy));
    chk("R9 R11 ld_ready", 32'(ld_ready), 32'(e_lrdy));
    chk("R8 inv_valid", 32'(inv_valid), 32'(q_m.size() > 0));
    if (q_m.size() > 0) begin
      chk("R3 R8 mask", 32'(inv_mask), 32'(q_m[0]));
      chk("R8 addr", 32'(inv_addr), 32'(q_a[0]));
    end
    s_acc = sv && e_srdy;
    l_acc = lv && e_lrdy;
    if (pop && q_m.size() > 0) begin void'(q_m.pop_front()); void'(q_a.pop_front()); end
    if (s_acc) begin
      m = exp_mask(sa);
      for (int c = 0; c < NC; c++)
        for (int w = 0; w < NW; w++)
          if (m_v[c][sa[SW-1:0]][w] && m_t[c][sa[SW-1:0]][w] == sa[LW-1:SW]) m_v[c][sa[SW-1:0]][w] = 0;
      if (m != '0) begin q_m.push_back(m); q_a.push_back(sa); end
    end
    if (l_acc) begin
      m_v[lc][la[SW-1:0]][lw] = 1;
      m_t[lc][la[SW-1:0]][lw] = la[LW-1:SW];
    end
    @(posedge clk); @(negedge clk);
    chk("R7 ack", 32'(st_ack), 32'(s_acc));
    if (s_acc) chk("R7 ack core", 32'(st_ack_core), 32'(sc));
  endtask

  task automatic idle(input bit pop);
    cycle(0, 0, '0, 0, 0, 0, '0, pop);
  endtask
  task automatic ld(input int c, input logic [LW-1:0] a, input int w);
    cycle(1, c, a, w, 0, 0, '0, 0);
  endtask
  task automatic st(input int c, input logic [LW-1:0] a, input bit pop);
    cycle(0, 0, '0, 0, 1, c, a, pop);
  endtask
  task automatic drain();
    while (q_m.size() > 0) idle(1);
  endtask

  initial begin
    int unsigned seed = 32'h5eed_1234;
    int r;
    ld_valid = 0; st_valid = 0; inv_ready = 0; ld_core = 0; st_core = 0;
    ld_line = '0; st_line = '0; ld_way = 0;
    for (int c = 0; c < NC; c++) for (int s = 0; s < NS; s++) for (int w = 0; w < NW; w++) m_v[c][s][w] = 0;
    r = $urandom(seed);
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 inv_valid", 32'(inv_valid), 0);
    chk("R1 st_ready", 32'(st_ready), 1);
    chk("R1 st_ack", 32'(st_ack), 0);
    // R1 R4: nothing tracked yet
    st(2, mk(7, 2), 0);
    chk("R1 R4 no inv", 32'(inv_valid), 0);
    // R2 R3: cores 1,3,5 hold the line; store from a holder
    ld(1, mk(7, 2), 0); ld(3, mk(7, 2), 2); ld(5, mk(7, 2), 3);
    st(3, mk(7, 2), 0);
    chk("R3 holders mask", 32'(inv_mask), 32'h2A);
    drain();
    // R5
    st(1, mk(7, 2), 0);
    chk("R5 no second inv", 32'(inv_valid), 0);
    // R12
    ld(0, mk(7, 2), 1);
    st(4, mk(8, 2), 0);
    chk("R12 tag miss", 32'(inv_valid), 0);
    st(4, mk(7, 2), 0);
    chk("R12 entry kept", 32'(inv_mask), 32'h01);
    drain();
    // R6
    ld(2, mk(9, 5), 1); ld(2, mk(10, 5), 1);
    st(0, mk(9, 5), 0);
    chk("R6 old line gone", 32'(inv_valid), 0);
    st(0, mk(10, 5), 0);
    chk("R6 new line", 32'(inv_mask), 32'h04);
    drain();
    // R9: same-set collision, store first
    cycle(1, 4, mk(11, 6), 0, 1, 6, mk(12, 6), 0);
    chk("R9 load held", 32'(inv_valid), 0);
    ld(4, mk(11, 6), 0);
    st(6, mk(11, 6), 0);
    chk("R9 load after", 32'(inv_mask), 32'h10);
    drain();
    // R11: different sets both taken
    cycle(1, 7, mk(13, 8), 3, 1, 0, mk(13, 9), 0);
    st(0, mk(13, 8), 0);
    chk("R11 load taken", 32'(inv_mask), 32'h80);
    drain();
    // R10: fill queue, fifth store stalls
    for (int i = 0; i < 5; i++) ld(i, mk(20 + i, 10 + i), 0);
    for (int i = 0; i < 4; i++) st(0, mk(20 + i, 10 + i), 0);
    chk("R10 full", 32'(st_ready), 0);
    st(0, mk(24, 14), 0);
    chk("R10 stalled no ack", 32'(st_ack), 0);
    drain();
    st(0, mk(24, 14), 0);
    chk("R10 applied later", 32'(inv_mask), 32'h10);
    drain();
    // random mix
    for (int i = 0; i < 3000; i++) begin
      cycle(($urandom % 2) == 0, $urandom % NC, mk($urandom % 4, $urandom % 4), $urandom % NW,
            ($urandom % 3) == 0, $urandom % NC, mk($urandom % 4, $urandom % 4),
            ($urandom % 10) < 7);
    end
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule